// File: doc/BRIEF.md
# Fixed-Priority Four-Master Bus Arbiter

This block chooses which of four masters owns a shared bus. Each master raises an active-low request. The arbiter answers with one of four active-low grant lines. Master 0 has the highest priority and master 3 the lowest, and the order never changes. A separate active-low lock line is driven by whichever master currently owns the bus. While the lock is low, ownership cannot pass to another master.

When a higher-priority master requests the bus, the present owner's grant is withdrawn at once, on the next clock edge, as a signal to finish up. The new grant is held back until the lock goes high. During that window no grant line is low. When the owner stops requesting and the lock is high, its grant is released. On the following edge the highest-priority waiting master is granted. An owner that keeps requesting, with no higher-priority request present, keeps the bus.

Top module: `bus_prio_arbiter`

## Requirements
- R1: While rst_n is low, and on the first edge after it rises with no requests, all four gnt_n bits are 1.
- R2: At most one gnt_n bit is 0 at any time. A 0 in bit i means master i owns the bus.
- R3: With no grant active, lock_n high and at least one req_n bit 0, the next rising edge grants the lowest-numbered requesting master. Bit 0 has the highest priority.
- R4: With no grant active and lock_n low, no grant is issued on the next edge, whatever the requests.
- R5: While master i holds a grant, a request from any master with a lower index removes every grant on the next edge. This holds whether lock_n is high or low.
- R6: While master i holds a grant and lock_n is low, with no higher-priority request, the grant is unchanged on the next edge, even if req_n[i] has gone high.
- R7: While master i holds a grant, lock_n is high, req_n[i] is high and there is no higher-priority request, the grant is removed on the next edge.
- R8: While master i holds a grant, req_n[i] is low, lock_n is high and there is no higher-priority request, the grant is kept on the next edge. Requests from lower-priority masters do not change this.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 4 | Active-low bus requests, bit 0 highest priority |
| lock_n | input | 1 | Active-low lock held by the current owner |
| gnt_n | output | 4 | Active-low one-hot grants |

## Verification
The only state in the block is the registered owner. If that state is wrong, it shows on gnt_n one edge after the inputs that should have set it, for example as a grant to the wrong index, a grant issued under lock, or a preempted grant that lingers. The bench predicts the owner edge by edge from the requirement rules and compares it with gnt_n every cycle. A single wrong transition is therefore reported in the cycle where it happens, and it does not surface only much later.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
    localparam int NUM_MASTERS = 4;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_GRANT = 2'd1,
        ACT_HOLD  = 2'd2,
        ACT_DROP  = 2'd3
    } arb_action_e;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick,
    output logic         any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1] = seen[i] | req[i];
        assign pick[i]   = req[i] & ~seen[i];
    end

    assign any = seen[N];
endmodule

// File: rtl/preempt_detect.sv
module preempt_detect #(
    parameter int N = 4
) (
    input  logic [N-1:0] owner,
    input  logic [N-1:0] req,
    output logic         preempt,
    output logic         own_req
);
    logic [N:0]   above;
    logic [N-1:0] hit;
    assign above[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign above[i+1] = above[i] | req[i];
        assign hit[i]     = owner[i] & above[i];
    end

    assign preempt = |hit;
    assign own_req = |(owner & req);
endmodule

// File: rtl/bus_prio_arbiter.sv
module bus_prio_arbiter
    import bus_arb_pkg::*;
#(
    parameter int N = NUM_MASTERS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_n,
    input  logic         lock_n,
    output logic [N-1:0] gnt_n
);
    typedef struct packed {
        logic [N-1:0] owner;
    } arb_state_t;

    arb_state_t  st_d, st_q;
    arb_action_e act;

    logic [N-1:0] req;
    logic         locked;
    logic [N-1:0] pick;
    logic         any_req;
    logic         preempt;
    logic         own_req;

    assign req    = ~req_n;
    assign locked = ~lock_n;

    prio_pick #(.N(N)) u_pick (
        .req  (req),
        .pick (pick),
        .any  (any_req)
    );

    preempt_detect #(.N(N)) u_pre (
        .owner   (st_q.owner),
        .req     (req),
        .preempt (preempt),
        .own_req (own_req)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.owner == '0) begin
            act = (!locked && any_req) ? ACT_GRANT : ACT_IDLE;
        end else if (preempt) begin
            act = ACT_DROP;
        end else if (!locked && !own_req) begin
            act = ACT_DROP;
        end else begin
            act = ACT_HOLD;
        end

        case (act)
            ACT_GRANT: st_d.owner = pick;
            ACT_DROP:  st_d.owner = '0;
            default:   st_d.owner = st_q.owner;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt_n = ~st_q.owner;

    // ---------------- assertions (port level) ----------------
    function automatic logic [N-1:0] low_bit(input logic [N-1:0] v);
        return v & (~v + 1'b1);
    endfunction

    logic [N-1:0] gnt_a;
    logic [N-1:0] higher_req;
    assign gnt_a      = ~gnt_n;
    assign higher_req = (~req_n) & (gnt_a - 1'b1);

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_a));

    assert_grant_highest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_a == '0 && lock_n && req_n != '1)
        |=> (gnt_a == low_bit(~$past(req_n))));

    assert_no_grant_under_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_a == '0 && !lock_n) |=> (gnt_a == '0));

    assert_preempt_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_a != '0 && higher_req != '0) |=> (gnt_a == '0));

    assert_hold_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_a != '0 && higher_req == '0 && !lock_n) |=> $stable(gnt_n));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_a != '0 && higher_req == '0 && lock_n && ((~req_n) & gnt_a) == '0)
        |=> (gnt_a == '0));

    assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_a != '0 && higher_req == '0 && lock_n && ((~req_n) & gnt_a) != '0)
        |=> $stable(gnt_n));
endmodule

// File: tb/bus_prio_arbiter_bench.sv
module bus_prio_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] req_n;
    logic       lock_n;
    logic [3:0] gnt_n;

    int checks = 0;
    int fails  = 0;
    logic [3:0] exp_own;   // expected owner, active high
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_prio_arbiter u_bus_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .lock_n(lock_n), .gnt_n(gnt_n)
    );

    // Next owner from the requirement rules (active-high arguments).
    function automatic logic [3:0] model(input logic [3:0] cur, input logic [3:0] rq,
                                         input logic lk);
        logic [3:0] up;
        if (cur == 4'b0) begin
            if (lk || rq == 4'b0) return 4'b0;
            for (int k = 0; k < 4; k++) if (rq[k]) return 4'b1 << k;
            return 4'b0;
        end
        up = 4'b0;
        for (int k = 0; k < 4; k++) begin
            if (cur[k]) break;
            up[k] = 1'b1;
        end
        if ((rq & up) != 4'b0) return 4'b0;
        if (lk) return cur;
        if ((rq & cur) == 4'b0) return 4'b0;
        return cur;
    endfunction

    function automatic string rule(input logic [3:0] cur, input logic [3:0] rq,
                                   input logic lk);
        logic [3:0] up;
        if (cur == 4'b0) return lk ? "R4" : "R3";
        up = 4'b0;
        for (int k = 0; k < 4; k++) begin
            if (cur[k]) break;
            up[k] = 1'b1;
        end
        if ((rq & up) != 4'b0) return "R5";
        if (lk) return "R6";
        if ((rq & cur) == 4'b0) return "R7";
        return "R8";
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: gnt_n=%b expected %b", tag, act, exp);
        end
    endtask

    // Apply inputs at falling edge, check after the next rising edge.
    task automatic step(input logic [3:0] rq, input logic lk);
        string tag;
        @(negedge clk);
        req_n  = ~rq;
        lock_n = ~lk;
        tag    = rule(exp_own, rq, lk);
        exp_own = model(exp_own, rq, lk);
        @(posedge clk);
        #1;
        check(tag, gnt_n, ~exp_own);
        check("R2", {3'b0, $onehot0(~gnt_n)}, 4'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        req_n  = 4'hF;
        lock_n = 1'b1;
        exp_own = 4'b0;
        #1;
        check("R1", gnt_n, 4'hF);
        @(negedge clk);
        rst_n = 1'b1;
        step(4'b0000, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; req_n = 4'hF; lock_n = 1'b1; exp_own = 4'b0;
        void'($urandom(32'd1753));
        do_reset();

        // R4: pending requests wait while lock is held
        step(4'b0100, 1'b1);
        step(4'b0100, 1'b1);
        // R3: lock released -> master 2
        step(4'b0100, 1'b0);
        // R8: lower request 3 does not disturb owner 2
        step(4'b1100, 1'b0);
        // R6: owner drops request under lock, keeps grant
        step(4'b1000, 1'b1);
        // R5: higher master 0 under lock -> grant dropped
        step(4'b1001, 1'b1);
        // R4: idle while lock still held
        step(4'b1001, 1'b1);
        // R3: lock released -> master 0 wins over 3
        step(4'b1001, 1'b0);
        // R7: owner 0 releases with lock inactive
        step(4'b1000, 1'b0);
        step(4'b1000, 1'b0);
        // R5 with lock inactive: owner 3 preempted by 1
        step(4'b1010, 1'b0);
        step(4'b1010, 1'b0);
        // R3 with all requesting
        step(4'b0000, 1'b0);
        step(4'b1111, 1'b0);
        // mid-run reset (R1)
        do_reset();

        for (int n = 0; n < 3000; n++) begin
            logic [3:0] rq;
            logic lk;
            rq = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) rq = exp_own | 4'($urandom_range(0, 15) & 4'b1000);
            lk = ($urandom_range(0, 2) == 0);
            step(rq, lk);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule